// File: doc/BRIEF.md
# Register Byte-Order Conversion Unit

This unit rewrites the byte order of one 64-bit register value. It takes no second operand: only the destination value, a class bit, a one-bit order select and a 32-bit immediate that gives the operation width. In the 32-bit class the order select chooses the target byte order. On a little-endian host, a conversion to little endian needs no reordering and only truncates to the width. A conversion to big endian reverses the bytes. In the 64-bit class the bytes are reversed every time, and the order select must be clear.

The result and an illegal flag are registered, one clock after the inputs. The host byte order is a parameter: little endian by default, or big endian through `HOST_BIG_ENDIAN`. An immediate that is not exactly 16, 32 or 64, or a set order select in the 64-bit class, raises the illegal flag and passes the destination through unchanged.

Top module: `bswap_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after release, `result` is 0 and `illegal` is 0.
- R2: `result` and `illegal` reflect the inputs sampled at the previous rising clock edge (latency one cycle).
- R3: With `is_alu64`=0 and `order_be`=0 on a little-endian host, `result` is the low W bits of `dst`, zero-extended to 64 bits, where W is the width.
- R4: With `is_alu64`=0 and `order_be`=1 on a little-endian host, `result` is the low W bits of `dst` with their bytes reversed, zero-extended.
- R5: With `is_alu64`=1 and `order_be`=0, `result` is the low W bits of `dst` byte-reversed, whatever the host order.
- R6: For W of 16 or 32 on a legal operation, all bits of `result` above W are 0.
- R7: W is taken from the whole 32-bit `imm`. Only the values 16, 32 and 64 (decimal) are legal. Any other value sets `illegal`=1, and `result` equals `dst` unchanged.
- R8: `is_alu64`=1 with `order_be`=1 sets `illegal`=1, and `result` equals `dst` unchanged.
- R9: Every legal combination of class, order select and width gives `illegal`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| is_alu64 | input | 1 | Class: 0 = 32-bit class (conditional conversion), 1 = 64-bit class (unconditional swap) |
| order_be | input | 1 | Order select: 0 = little-endian target, 1 = big-endian target |
| imm | input | 32 | Width code: 16, 32 or 64 |
| dst | input | 64 | Destination register value |
| result | output | 64 | Converted value, registered |
| illegal | output | 1 | Unsupported width or class/order combination, registered |

## Verification
The bench targets the case where one opcode has two meanings. In the 32-bit class with order 0, a design that swaps anyway returns reversed bytes instead of a truncated value. In the 64-bit class, a design that obeys the order bit fails to swap. Immediates that differ from a legal width only in their upper bits, negative immediates and a width of 8 all test that the full immediate is decoded. A design that checks only the low bits would accept them and report them as legal. The bench also checks that no stale upper bytes survive a 16-bit or 32-bit result, and that the destination passes through unchanged when an operation is refused.

// File: rtl/bswap_pkg.sv
package bswap_pkg;
   // Width selector shared by the decoder and the output mux
   typedef enum logic [1:0] {
      SW_W16 = 2'd0,
      SW_W32 = 2'd1,
      SW_W64 = 2'd2
   } sw_width_e;

   localparam int unsigned BYTE_W   = 8;
   localparam int unsigned N_WIDTHS = 3;
   localparam int unsigned MIN_W    = 16;
endpackage

// File: rtl/bswap_decode.sv
module bswap_decode
   import bswap_pkg::*;
#(
   parameter int unsigned IMM_W           = 32,
   parameter bit          HOST_BIG_ENDIAN = 1'b0
) (
   input  logic             is_alu64,
   input  logic             order_be,
   input  logic [IMM_W-1:0] imm,
   output sw_width_e        width,
   output logic             reorder,
   output logic             illegal
);
   if (IMM_W < 7) begin : g_bad_imm
      $error("bswap_decode: IMM_W must hold the value 64");
   end

   logic width_ok;
   logic conv_swap;

   // the whole immediate is compared, so no upper bits are ignored
   always_comb begin
      width    = SW_W64;
      width_ok = 1'b1;
      if (imm == IMM_W'(16))      width = SW_W16;
      else if (imm == IMM_W'(32)) width = SW_W32;
      else if (imm == IMM_W'(64)) width = SW_W64;
      else                        width_ok = 1'b0;
   end

   // the host order picks which order select requires a reversal
   if (HOST_BIG_ENDIAN) begin : g_host_be
      assign conv_swap = ~order_be;
   end else begin : g_host_le
      assign conv_swap = order_be;
   end

   assign reorder = is_alu64 | conv_swap;
   assign illegal = ~width_ok | (is_alu64 & order_be);

   // R7: a recognised width is never reported alongside a bad width code
   always_comb begin
      if (!$isunknown(imm) && (imm == IMM_W'(16) || imm == IMM_W'(32)))
         a_r7_width_decoded: assert (width != SW_W64 && width_ok);
   end
endmodule

// File: rtl/bswap_lanes.sv
module bswap_lanes
   import bswap_pkg::*;
#(
   parameter int unsigned DATA_W = 64
) (
   input  logic [DATA_W-1:0]                dst,
   output logic [N_WIDTHS-1:0][DATA_W-1:0] swapped,
   output logic [N_WIDTHS-1:0][DATA_W-1:0] plain
);
   if (DATA_W != (MIN_W << (N_WIDTHS - 1))) begin : g_bad_width
      $error("bswap_lanes: DATA_W must equal the widest swap");
   end

   for (genvar g = 0; g < N_WIDTHS; g++) begin : g_width
      localparam int unsigned W  = MIN_W << g;
      localparam int unsigned NB = W / BYTE_W;

      // byte b of the result takes byte NB-1-b of the input
      for (genvar b = 0; b < NB; b++) begin : g_byte
         assign swapped[g][b*BYTE_W +: BYTE_W] = dst[(NB-1-b)*BYTE_W +: BYTE_W];
      end
      assign plain[g][W-1:0] = dst[W-1:0];

      if (W < DATA_W) begin : g_zext
         assign swapped[g][DATA_W-1:W] = '0;
         assign plain[g][DATA_W-1:W]   = '0;
      end
   end
endmodule

// File: rtl/bswap_unit.sv
module bswap_unit
   import bswap_pkg::*;
#(
   parameter int unsigned DATA_W          = 64,
   parameter int unsigned IMM_W           = 32,
   parameter bit          HOST_BIG_ENDIAN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              is_alu64,
   input  logic              order_be,
   input  logic [IMM_W-1:0]  imm,
   input  logic [DATA_W-1:0] dst,
   output logic [DATA_W-1:0] result,
   output logic              illegal
);
   localparam int unsigned W16 = MIN_W;
   localparam int unsigned W32 = MIN_W * 2;

   sw_width_e                       width;
   logic                            reorder;
   logic                            bad_op;
   logic [N_WIDTHS-1:0][DATA_W-1:0] swapped;
   logic [N_WIDTHS-1:0][DATA_W-1:0] plain;
   logic [DATA_W-1:0]               next_res;

   bswap_decode #(.IMM_W(IMM_W), .HOST_BIG_ENDIAN(HOST_BIG_ENDIAN)) u_dec (
      .is_alu64 (is_alu64),
      .order_be (order_be),
      .imm      (imm),
      .width    (width),
      .reorder  (reorder),
      .illegal  (bad_op)
   );

   bswap_lanes #(.DATA_W(DATA_W)) u_lanes (
      .dst     (dst),
      .swapped (swapped),
      .plain   (plain)
   );

   always_comb begin
      if (bad_op)       next_res = dst;
      else if (reorder) next_res = swapped[width];
      else              next_res = plain[width];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result  <= '0;
         illegal <= 1'b0;
      end else begin
         result  <= next_res;
         illegal <= bad_op;
      end
   end

   // R8: 64-bit class with the order select set is refused
   a_r8_alu64_order_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (is_alu64 && order_be) |=> illegal);

   // R7 / R8: a refused operation hands the destination back untouched
   a_r7_refused_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> result == $past(dst));

   // R6: 16-bit results carry no upper bits
   a_r6_w16_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!illegal && $past(imm) == IMM_W'(W16)) |-> result[DATA_W-1:W16] == '0);

   // R6: 32-bit results carry no upper bits
   a_r6_w32_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!illegal && $past(imm) == IMM_W'(W32)) |-> result[DATA_W-1:W32] == '0);

   // R9: a 32-bit-class request at width 64 is always accepted
   a_r9_legal_accepted: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_alu64 && imm == IMM_W'(64)) |=> !illegal);
endmodule

// File: tb/sim_bswap_unit.sv
module sim_bswap_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        is_alu64 = 1'b0;
   logic        order_be = 1'b0;
   logic [31:0] imm = '0;
   logic [63:0] dst = '0;
   logic [63:0] result;
   logic        illegal;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #2 clk = ~clk;  // 250 MHz

   bswap_unit u0 (.*);

   // vector: {alu64, order, imm, dst, expected result, expected illegal}
   localparam int NV = 17;
   localparam logic [63:0] DA = 64'h0123456789ABCDEF;
   localparam logic [63:0] DB = 64'hF0E1D2C3B4A59687;
   localparam logic [162:0] VEC [NV] = '{
      {1'b0, 1'b0, 32'd16, DA, 64'h000000000000CDEF, 1'b0},  // R3
      {1'b0, 1'b0, 32'd32, DA, 64'h0000000089ABCDEF, 1'b0},  // R3
      {1'b0, 1'b0, 32'd64, DA, DA,                   1'b0},  // R3
      {1'b0, 1'b1, 32'd16, DA, 64'h000000000000EFCD, 1'b0},  // R4
      {1'b0, 1'b1, 32'd32, DA, 64'h00000000EFCDAB89, 1'b0},  // R4
      {1'b0, 1'b1, 32'd64, DA, 64'hEFCDAB8967452301, 1'b0},  // R4
      {1'b1, 1'b0, 32'd16, DA, 64'h000000000000EFCD, 1'b0},  // R5
      {1'b1, 1'b0, 32'd32, DA, 64'h00000000EFCDAB89, 1'b0},  // R5
      {1'b1, 1'b0, 32'd64, DA, 64'hEFCDAB8967452301, 1'b0},  // R5
      {1'b0, 1'b1, 32'd16, DB, 64'h0000000000008796, 1'b0},  // R6
      {1'b1, 1'b0, 32'd32, DB, 64'h000000008796A5B4, 1'b0},  // R6
      {1'b0, 1'b0, 32'd32, DB, 64'h00000000B4A59687, 1'b0},  // R6
      {1'b1, 1'b1, 32'd64, DA, DA,                   1'b1},  // R8
      {1'b0, 1'b0, 32'd8,  DA, DA,                   1'b1},  // R7
      {1'b0, 1'b1, 32'h00010010, DA, DA,             1'b1},  // R7
      {1'b1, 1'b0, 32'd0,  DB, DB,                   1'b1},  // R7
      {1'b0, 1'b1, 32'hFFFFFFF0, DB, DB,             1'b1}   // R7
   };

   function automatic logic [64:0] model(input logic a64, input logic obe,
                                         input logic [31:0] w, input logic [63:0] d);
      logic [63:0] r;
      int nb;
      if (w != 32'd16 && w != 32'd32 && w != 32'd64) return {1'b1, d};
      if (a64 && obe) return {1'b1, d};
      nb = int'(w) / 8;
      r = '0;
      for (int i = 0; i < nb; i++) begin
         if (a64 || obe) r[8*i +: 8] = d[8*(nb-1-i) +: 8];
         else            r[8*i +: 8] = d[8*i +: 8];
      end
      return {1'b0, r};
   endfunction

   task automatic check(input string tag, input logic [63:0] er, input logic ei);
      n_cmp++;
      if (result !== er || illegal !== ei) begin
         n_bad++;
         $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b",
                  tag, result, illegal, er, ei);
      end
   endtask

   task automatic apply(input logic a, input logic o, input logic [31:0] w,
                        input logic [63:0] d);
      @(negedge clk);
      is_alu64 = a; order_be = o; imm = w; dst = d;
      @(negedge clk);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 20000) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: cycles=%0d expected completion", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [63:0] lfsr;
      logic [64:0] exp;
      // R1: reset state, with an input that would otherwise change the outputs
      is_alu64 = 1'b1; order_be = 1'b1; imm = 32'd5; dst = DA;
      repeat (3) @(negedge clk);
      check("R1 in reset", 64'd0, 1'b0);
      rst_n = 1'b1;
      is_alu64 = 1'b0; order_be = 1'b0; imm = 32'd64; dst = '0;
      @(negedge clk);
      check("R1 after release", 64'd0, 1'b0);

      // R3-R8: vector table
      for (int k = 0; k < NV; k++) begin
         apply(VEC[k][162], VEC[k][161], VEC[k][160:129], VEC[k][128:65]);
         check($sformatf("R3-8 vec %0d", k), VEC[k][64:1], VEC[k][0]);
      end

      // R2: one-cycle latency, back-to-back changes
      @(negedge clk);
      is_alu64 = 1'b1; order_be = 1'b0; imm = 32'd16; dst = 64'h0000_0000_0000_1122;
      @(negedge clk);
      is_alu64 = 1'b0; order_be = 1'b0; imm = 32'd16; dst = 64'hFFFF_FFFF_FFFF_3344;
      check("R2 first", 64'h2211, 1'b0);
      @(negedge clk);
      check("R2 second", 64'h3344, 1'b0);

      // R9: all legal combinations, plus model-based sweep
      lfsr = 64'hACE1_2468_1357_BDF0;
      for (int k = 0; k < 48; k++) begin
         logic [31:0] w;
         logic a, o;
         lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
         case (k % 4)
            0: w = 32'd16;
            1: w = 32'd32;
            2: w = 32'd64;
            default: w = 32'd48;
         endcase
         a = lfsr[5];
         o = lfsr[9] & ~(k < 24 && a);
         apply(a, o, w, lfsr);
         exp = model(a, o, w, lfsr);
         check($sformatf("R9 sweep %0d", k), exp[63:0], exp[64]);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule